// File: doc/BRIEF.md
# Sigma-Delta Two-Stage Decimation Chain

This block turns the single-bit, full-rate output of a sigma-delta modulator into signed 24-bit conversion words. The first stage is a third-order cascaded integrator-comb decimator whose ratio is set at run time. Its output can pass through a chop demodulator, which flips the sign of every other word and averages adjacent pairs so that a constant offset cancels.

A second stage then smooths the words. There are three ways through it:
- a fixed 22-tap symmetric FIR (the normal path);
- a direct bypass, where the decimator output is the only filtering;
- a 4-word running mean, which takes over after a large input step and stays in place until the FIR window again holds only post-step samples.

The last stage subtracts a calibration offset, multiplies by an unsigned fixed-point gain and saturates the result. Each result word comes with a one-cycle valid strobe. Any change to the ratio or to the mode bits clears all filter state, so stale data never mixes with the new setting.

Top module: `sd_decim_chain`

## Requirements
- R1: Each clock, bit value 1 counts as +1 and 0 counts as −1. With a constant stream, decimation ratio R, bypass on, chop off, offset 0 and gain 1.0, the settled word is +R³ for all ones and −R³ for all zeros.
- R2: With a ratio R of at least 2, `data_valid` is high for exactly one cycle, and consecutive pulses are exactly R clocks apart.
- R3: A change of `dec_ratio`, `chop_en`, `skip_en` or `fast_en` clears all filter and pipeline state. With bypass on and a constant-ones stream, the first word after a change to ratio R is (R−1)(R−2)(R−3)/6.
- R4: The FIR uses 22 taps. The coefficient of tap i (i = 0 to 21) is min(i+1, 22−i), except that the two centre taps are 9, so the coefficients sum to 128. The tap sum is shifted right arithmetically by 7 bits, which gives a DC gain of exactly 1. With bypass off, a constant input settles to the same word as in R1.
- R5: When `skip_en` is 1, the FIR is bypassed. After a change in the stream, the output reaches the new settled value within 5 words.
- R6: When `chop_en` is 1, the first decimator word after a flush is taken positive and the next one negated, alternating from then on. Each output is the arithmetic half-sum of the current and previous signed words. A constant stream therefore settles to 0, both in bypass and through the FIR.
- R7: When `fast_en` is 1, a decimator word whose absolute difference from the previous word exceeds `step_thresh` starts fast mode. The mean of the last 4 words is output for that word and for the following 22 words; after that the FIR output returns. When `fast_en` is 0, the FIR output is used at all times.
- R8: The output word is ((filtered − `cal_offset`) × `cal_gain`) shifted right arithmetically by 23 bits. This rounds toward minus infinity; `cal_gain` is unsigned with 23 fraction bits (0x800000 = 1.0).
- R9: A scaled result above 8388607 outputs 8388607, and one below −8388608 outputs −8388608.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one modulator bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator bitstream |
| dec_ratio | input | DEC_W | Decimation ratio R (2 or more) |
| chop_en | input | 1 | Enable chop demodulation of decimator words |
| skip_en | input | 1 | Bypass the FIR stage |
| fast_en | input | 1 | Enable step detection and the fast mean path |
| step_thresh | input | 3*DEC_W+2 | Unsigned step-detection threshold |
| cal_offset | input | OUT_W | Signed calibration offset |
| cal_gain | input | OUT_W | Unsigned gain, OUT_W-1 fraction bits |
| data_out | output | OUT_W | Signed conversion word |
| data_valid | output | 1 | One-cycle strobe for each new word |

## Verification
The bench builds the chain with its default widths: a 6-bit ratio field, which gives a 20-bit decimator word, and a 24-bit output. It drives ratios of 8 and 16, so the settled values of ±512 and 4096 and the partial first word of 455 after a flush can be computed exactly. With a 24-bit output, large calibration offsets can push the scaled value past both ends of the range, which exercises saturation. A ratio of 8 makes the 22-word FIR settle window short enough to observe in a few hundred cycles, so the fast path, the FIR-only path and the return to the FIR can all be compared against the same input step.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   localparam int FIR_TAPS  = 22;
   localparam int FIR_SHIFT = 7;
   localparam int COEF_W    = 5;

   typedef enum logic [1:0] {
      PATH_FIR  = 2'd0,
      PATH_SINC = 2'd1,
      PATH_FAST = 2'd2
   } path_e;

   // triangular window, centre pair trimmed so the sum is 2**FIR_SHIFT
   function automatic int fir_coef(input int idx);
      int t;
      t = (idx + 1 < FIR_TAPS - idx) ? idx + 1 : FIR_TAPS - idx;
      return (t == FIR_TAPS / 2) ? t - 2 : t;
   endfunction

endpackage

// File: rtl/sdc_sinc3.sv
module sdc_sinc3 #(
   parameter int DEC_W = 6,
   parameter int ORDER = 3,
   localparam int W = ORDER * DEC_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                bit_in,
   input  logic [DEC_W-1:0]    ratio,
   output logic                out_vld,
   output logic signed [W-1:0] out_data
);

   logic signed [W-1:0] integ [ORDER];
   logic signed [W-1:0] dly   [ORDER];
   logic signed [W-1:0] diff  [ORDER];
   logic [DEC_W-1:0]    phase_cnt;
   logic                dec_hit;
   logic signed [W-1:0] x_in;

   assign x_in    = bit_in ? W'(1) : -W'(1);
   assign dec_hit = (phase_cnt >= ratio - 1'b1);

   always_comb begin
      diff[0] = integ[ORDER-1] - dly[0];
      for (int s = 1; s < ORDER; s++) diff[s] = diff[s-1] - dly[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < ORDER; s++) begin
            integ[s] <= '0;
            dly[s]   <= '0;
         end
         phase_cnt <= '0;
         out_vld   <= 1'b0;
         out_data  <= '0;
      end else if (flush) begin
         for (int s = 0; s < ORDER; s++) begin
            integ[s] <= '0;
            dly[s]   <= '0;
         end
         phase_cnt <= '0;
         out_vld   <= 1'b0;
         out_data  <= '0;
      end else begin
         integ[0] <= integ[0] + x_in;
         for (int s = 1; s < ORDER; s++) integ[s] <= integ[s] + integ[s-1];
         out_vld <= dec_hit;
         if (dec_hit) begin
            phase_cnt <= '0;
            dly[0]    <= integ[ORDER-1];
            for (int s = 1; s < ORDER; s++) dly[s] <= diff[s-1];
            out_data  <= diff[ORDER-1];
         end else begin
            phase_cnt <= phase_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sdc_chop.sv
module sdc_chop #(
   parameter int W = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                en,
   input  logic                in_vld,
   input  logic signed [W-1:0] in_data,
   output logic                out_vld,
   output logic signed [W-1:0] out_data
);

   logic                negate_q;
   logic signed [W-1:0] prev_q;
   logic signed [W-1:0] cur_s;
   logic signed [W:0]   pair_sum;

   assign cur_s    = negate_q ? -in_data : in_data;
   assign pair_sum = {cur_s[W-1], cur_s} + {prev_q[W-1], prev_q};
   assign out_vld  = in_vld;
   assign out_data = en ? W'(pair_sum >>> 1) : in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         negate_q <= 1'b0;
         prev_q   <= '0;
      end else if (flush) begin
         negate_q <= 1'b0;
         prev_q   <= '0;
      end else if (in_vld) begin
         negate_q <= ~negate_q;
         prev_q   <= cur_s;
      end
   end

endmodule

// File: rtl/sdc_stage2.sv
module sdc_stage2 #(
   parameter int W        = 20,
   parameter int AVG_LOG2 = 2,
   localparam int TAPS    = sdc_pkg::FIR_TAPS,
   localparam int CW      = sdc_pkg::COEF_W,
   localparam int PW      = W + CW,
   localparam int AW      = PW + $clog2(TAPS),
   localparam int AVG_N   = 1 << AVG_LOG2,
   localparam int CNT_W   = $clog2(TAPS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                skip,
   input  logic                fast_en,
   input  logic [W-1:0]        thresh,
   input  logic                in_vld,
   input  logic signed [W-1:0] in_data,
   output logic                out_vld,
   output logic signed [W-1:0] out_data
);
   import sdc_pkg::*;

   logic signed [W-1:0]  taps_q [TAPS-1];
   logic signed [W-1:0]  hist_q [AVG_N-1];
   logic signed [W-1:0]  window [TAPS];
   logic signed [PW-1:0] prod   [TAPS];
   logic signed [AW-1:0] acc;
   logic signed [W+AVG_LOG2-1:0] avg_sum;
   logic signed [W-1:0]  prev_q;
   logic signed [W:0]    delta;
   logic [W:0]           delta_mag;
   logic                 step_hit;
   logic [CNT_W-1:0]     settle_q;
   path_e                path;
   logic signed [W-1:0]  sel_data;

   assign window[0] = in_data;
   for (genvar k = 1; k < TAPS; k++) begin : g_win
      assign window[k] = taps_q[k-1];
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      localparam logic signed [CW-1:0] CK = CW'(fir_coef(k));
      logic signed [PW-1:0] wide;
      assign wide    = {{CW{window[k][W-1]}}, window[k]};
      assign prod[k] = wide * {{W{CK[CW-1]}}, CK};
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++) acc = acc + {{(AW-PW){prod[k][PW-1]}}, prod[k]};
      avg_sum = {{AVG_LOG2{in_data[W-1]}}, in_data};
      for (int k = 0; k < AVG_N - 1; k++)
         avg_sum = avg_sum + {{AVG_LOG2{hist_q[k][W-1]}}, hist_q[k]};
   end

   assign delta     = {in_data[W-1], in_data} - {prev_q[W-1], prev_q};
   assign delta_mag = delta[W] ? (W+1)'(-delta) : (W+1)'(delta);
   assign step_hit  = fast_en && (delta_mag > {1'b0, thresh});

   always_comb begin
      if (skip)                               path = PATH_SINC;
      else if (step_hit || (fast_en && settle_q != '0)) path = PATH_FAST;
      else                                    path = PATH_FIR;
      case (path)
         PATH_SINC: sel_data = in_data;
         PATH_FAST: sel_data = W'(avg_sum >>> AVG_LOG2);
         default:   sel_data = W'(acc >>> FIR_SHIFT);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS - 1; k++) taps_q[k] <= '0;
         for (int k = 0; k < AVG_N - 1; k++) hist_q[k] <= '0;
         prev_q   <= '0;
         settle_q <= '0;
         out_vld  <= 1'b0;
         out_data <= '0;
      end else if (flush) begin
         for (int k = 0; k < TAPS - 1; k++) taps_q[k] <= '0;
         for (int k = 0; k < AVG_N - 1; k++) hist_q[k] <= '0;
         prev_q   <= '0;
         settle_q <= '0;
         out_vld  <= 1'b0;
         out_data <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            taps_q[0] <= in_data;
            for (int k = 1; k < TAPS - 1; k++) taps_q[k] <= taps_q[k-1];
            hist_q[0] <= in_data;
            for (int k = 1; k < AVG_N - 1; k++) hist_q[k] <= hist_q[k-1];
            prev_q   <= in_data;
            out_data <= sel_data;
            if (step_hit)              settle_q <= CNT_W'(TAPS);
            else if (settle_q != '0)   settle_q <= settle_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/sdc_calib.sv
module sdc_calib #(
   parameter int W     = 20,
   parameter int OUT_W = 24,
   localparam int FRAC = OUT_W - 1,
   localparam int PW   = 2 * OUT_W + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic                    in_vld,
   input  logic signed [W-1:0]     in_data,
   input  logic signed [OUT_W-1:0] offset,
   input  logic [OUT_W-1:0]        gain,
   output logic                    out_vld,
   output logic signed [OUT_W-1:0] out_data
);

   localparam logic signed [PW-1:0] SAT_HI = PW'(2 ** (OUT_W - 1) - 1);
   localparam logic signed [PW-1:0] SAT_LO = -SAT_HI - PW'(1);

   logic signed [OUT_W:0] centred;
   logic signed [OUT_W:0] gain_s;
   logic signed [PW-1:0]  prod;
   logic signed [PW-1:0]  scaled;
   logic signed [OUT_W-1:0] clipped;

   assign centred = {{(OUT_W + 1 - W){in_data[W-1]}}, in_data} - {offset[OUT_W-1], offset};
   assign gain_s  = {1'b0, gain};
   assign prod    = centred * gain_s;
   assign scaled  = prod >>> FRAC;

   always_comb begin
      if (scaled > SAT_HI)      clipped = OUT_W'(SAT_HI);
      else if (scaled < SAT_LO) clipped = OUT_W'(SAT_LO);
      else                      clipped = OUT_W'(scaled);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else if (flush) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_data <= clipped;
      end
   end

endmodule

// File: rtl/sd_decim_chain.sv
module sd_decim_chain #(
   parameter int DEC_W    = 6,
   parameter int OUT_W    = 24,
   parameter int AVG_LOG2 = 2,
   localparam int SW      = 3 * DEC_W + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mod_bit,
   input  logic [DEC_W-1:0]        dec_ratio,
   input  logic                    chop_en,
   input  logic                    skip_en,
   input  logic                    fast_en,
   input  logic [3*DEC_W+1:0]      step_thresh,
   input  logic signed [OUT_W-1:0] cal_offset,
   input  logic [OUT_W-1:0]        cal_gain,
   output logic signed [OUT_W-1:0] data_out,
   output logic                    data_valid
);

   if (DEC_W < 2)      begin : g_bad_dec  $error("DEC_W must be at least 2");        end
   if (SW > OUT_W)     begin : g_bad_out  $error("OUT_W too narrow for sinc word");  end
   if (OUT_W > 31)     begin : g_bad_wide $error("OUT_W must not exceed 31");        end
   if (AVG_LOG2 < 1)   begin : g_bad_avg  $error("AVG_LOG2 must be at least 1");     end

   localparam int CFG_W = DEC_W + 3;

   logic [CFG_W-1:0]     cfg_now, cfg_q;
   logic                 flush;
   logic                 s1_vld, ch_vld, s2_vld;
   logic signed [SW-1:0] s1_data, ch_data, s2_data;

   assign cfg_now = {dec_ratio, chop_en, skip_en, fast_en};
   assign flush   = (cfg_now != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

   sdc_sinc3 #(.DEC_W(DEC_W), .ORDER(3)) u_sinc (
      .clk(clk), .rst_n(rst_n), .flush(flush), .bit_in(mod_bit), .ratio(dec_ratio),
      .out_vld(s1_vld), .out_data(s1_data));

   sdc_chop #(.W(SW)) u_chop (
      .clk(clk), .rst_n(rst_n), .flush(flush), .en(chop_en),
      .in_vld(s1_vld), .in_data(s1_data), .out_vld(ch_vld), .out_data(ch_data));

   sdc_stage2 #(.W(SW), .AVG_LOG2(AVG_LOG2)) u_stage2 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .skip(skip_en), .fast_en(fast_en),
      .thresh(step_thresh), .in_vld(ch_vld), .in_data(ch_data),
      .out_vld(s2_vld), .out_data(s2_data));

   sdc_calib #(.W(SW), .OUT_W(OUT_W)) u_calib (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_vld(s2_vld), .in_data(s2_data),
      .offset(cal_offset), .gain(cal_gain), .out_vld(data_valid), .out_data(data_out));

endmodule

// File: rtl/sd_decim_chain_chk.sv
module sd_decim_chain_chk #(
   parameter int DEC_W = 6,
   parameter int OUT_W = 24,
   localparam int SW   = 3 * DEC_W + 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    flush,
   input logic [DEC_W-1:0]        dec_ratio,
   input logic                    chop_en,
   input logic                    skip_en,
   input logic signed [OUT_W-1:0] cal_offset,
   input logic [OUT_W-1:0]        cal_gain,
   input logic                    s1_vld,
   input logic signed [SW-1:0]    s1_data,
   input logic signed [SW-1:0]    ch_data,
   input logic                    s2_vld,
   input logic signed [SW-1:0]    s2_data,
   input logic                    data_valid,
   input logic signed [OUT_W-1:0] data_out
);

   localparam logic [OUT_W-1:0] UNITY = OUT_W'(1) << (OUT_W - 1);

   logic                 seen_q;
   logic signed [SW-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      begin seen_q <= 1'b0; last_q <= '0; end
      else if (flush)  begin seen_q <= 1'b0; last_q <= '0; end
      else if (s1_vld) begin seen_q <= 1'b1; last_q <= s1_data; end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && dec_ratio > 1) |=> !data_valid); // R2

   AST_STAGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n || flush)
      s1_vld |=> s2_vld); // R2

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!s1_vld && !s2_vld && !data_valid)); // R3

   AST_SKIP_PASSES: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (skip_en && s1_vld && !chop_en) |=> (s2_data == $past(s1_data))); // R5

   AST_CHOP_CANCELS: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (chop_en && s1_vld && seen_q && s1_data == last_q) |-> (ch_data == '0)); // R6

   AST_UNITY_CAL: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (s2_vld && cal_gain == UNITY && cal_offset == '0) |=>
      (data_out == $past({{(OUT_W-SW){s2_data[SW-1]}}, s2_data}))); // R8

endmodule

bind sd_decim_chain sd_decim_chain_chk #(.DEC_W(DEC_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .dec_ratio(dec_ratio),
   .chop_en(chop_en), .skip_en(skip_en), .cal_offset(cal_offset), .cal_gain(cal_gain),
   .s1_vld(s1_vld), .s1_data(s1_data), .ch_data(ch_data),
   .s2_vld(s2_vld), .s2_data(s2_data), .data_valid(data_valid), .data_out(data_out));

// File: tb/sd_decim_chain_test.sv
`timescale 1ns/1ps
module sd_decim_chain_test;

   localparam int DEC_W = 6;
   localparam int OUT_W = 24;
   localparam int SW    = 3 * DEC_W + 2;
   localparam logic [OUT_W-1:0] G_ONE  = 24'h800000;
   localparam logic [OUT_W-1:0] G_HALF = 24'h400000;
   localparam logic [OUT_W-1:0] G_MAX  = 24'hFFFFFF;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    mod_bit = 1'b0;
   logic [DEC_W-1:0]        dec_ratio = 6'd8;
   logic                    chop_en = 1'b0, skip_en = 1'b0, fast_en = 1'b0;
   logic [SW-1:0]           step_thresh = 20'd100;
   logic signed [OUT_W-1:0] cal_offset = '0;
   logic [OUT_W-1:0]        cal_gain = G_ONE;
   logic signed [OUT_W-1:0] data_out;
   logic                    data_valid;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sd_decim_chain #(.DEC_W(DEC_W), .OUT_W(OUT_W)) uut (
      .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .dec_ratio(dec_ratio),
      .chop_en(chop_en), .skip_en(skip_en), .fast_en(fast_en), .step_thresh(step_thresh),
      .cal_offset(cal_offset), .cal_gain(cal_gain), .data_out(data_out), .data_valid(data_valid));

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_out(input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (!data_valid);
      end
   endtask

   task automatic set_cfg(input int r, input logic ch, input logic sk, input logic fs);
      @(negedge clk);
      dec_ratio = DEC_W'(r); chop_en = ch; skip_en = sk; fast_en = fs;
   endtask

   task automatic t_reset();
      chk("R2 reset valid", data_valid, 0);
      chk("R2 reset data", data_out, 0);
   endtask

   task automatic t_bypass_dc();
      set_cfg(8, 0, 1, 0); mod_bit = 1'b1;
      wait_out(10); chk("R1 ones R=8", data_out, 512);
      mod_bit = 1'b0;
      wait_out(10); chk("R1 zeros R=8", data_out, -512);
   endtask

   task automatic t_period_flush();
      int gap;
      set_cfg(8, 0, 1, 0); mod_bit = 1'b1;
      wait_out(6);
      gap = 0; do begin @(negedge clk); gap++; end while (!data_valid);
      chk("R2 period R=8", gap, 8);
      @(negedge clk); chk("R2 single pulse", data_valid, 0);
      set_cfg(16, 0, 1, 0);
      wait_out(1); chk("R3 first word after flush", data_out, 455);
      wait_out(5); chk("R1 ones R=16", data_out, 4096);
      gap = 0; do begin @(negedge clk); gap++; end while (!data_valid);
      chk("R2 period R=16", gap, 16);
   endtask

   task automatic t_skip_step();
      set_cfg(8, 0, 1, 0); mod_bit = 1'b0;
      wait_out(10);
      mod_bit = 1'b1;
      wait_out(5); chk("R5 bypass follows step", data_out, 512);
   endtask

   task automatic t_fir_paths();
      set_cfg(8, 0, 0, 0); mod_bit = 1'b0;
      wait_out(40); chk("R4 FIR settled zeros", data_out, -512);
      mod_bit = 1'b1;
      wait_out(8); chk("R7 FIR only still negative", (data_out < 0) ? 1 : 0, 1);
      wait_out(30); chk("R4 FIR settled ones", data_out, 512);
      set_cfg(8, 0, 0, 1); mod_bit = 1'b0;
      wait_out(40); chk("R7 fast mode settled zeros", data_out, -512);
      mod_bit = 1'b1;
      wait_out(8); chk("R7 fast mean after step", data_out, 512);
      wait_out(40); chk("R7 back on FIR", data_out, 512);
   endtask

   task automatic t_chop();
      set_cfg(8, 1, 1, 0); mod_bit = 1'b1;
      wait_out(10); chk("R6 chop bypass cancels", data_out, 0);
      set_cfg(8, 1, 0, 0);
      wait_out(40); chk("R6 chop FIR cancels", data_out, 0);
   endtask

   task automatic t_calib();
      set_cfg(8, 0, 1, 0); mod_bit = 1'b1;
      cal_offset = 24'sd12; cal_gain = G_ONE;
      wait_out(10); chk("R8 offset", data_out, 500);
      cal_offset = 24'sd0; cal_gain = G_HALF;
      wait_out(3); chk("R8 half gain", data_out, 256);
      cal_offset = 24'sd13;
      wait_out(3); chk("R8 floor positive", data_out, 249);
      mod_bit = 1'b0; cal_offset = 24'sd1;
      wait_out(8); chk("R8 floor negative", data_out, -257);
      mod_bit = 1'b1; cal_offset = -24'sd8000000; cal_gain = G_MAX;
      wait_out(8); chk("R9 saturate high", data_out, 8388607);
      mod_bit = 1'b0; cal_offset = 24'sd8000000;
      wait_out(8); chk("R9 saturate low", data_out, -8388608);
      cal_offset = '0; cal_gain = G_ONE;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_bypass_dc();
      t_period_flush();
      t_skip_step();
      t_fir_paths();
      t_chop();
      t_calib();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule